// File: doc/BRIEF.md
# Burst Column Address Generator

This block walks through the column addresses of one memory burst. A start pulse loads a starting column, a three-bit length code and an ordering bit. From the next cycle the block presents one column per beat on `col_o` with `valid_o` high. Each cycle in which `adv_i` is high moves it on to the following column. Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the start column. They walk that block either by counting up with wrap-around or by XOR-ing the start offset with the beat number. The page mode walks the whole row and wraps at its end. It runs until `term_i` stops it.

The output side behaves like a stream. `valid_o` says a column is presented and `adv_i` acts as the consumer's ready. A beat is taken on a clock edge where both are high. While `adv_i` is low the column and `last_o` hold, which gives clock-suspend behaviour. A new start pulse always wins: it drops whatever burst is running and presents its own first column on the next cycle.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and after it is released, `valid_o` and `last_o` are 0 and `col_o` is 0 until the first start.
- R2: A start pulse makes `valid_o` 1 and `col_o` equal to the start column on the next cycle. This holds even when a burst is already running, which it replaces.
- R3: While a burst is valid and `adv_i`, `term_i` and `start_i` are all low, `col_o` and `valid_o` keep their values across the clock edge.
- R4: With the ordering bit 0 and a fixed length L, beat k shows the start column with its low log2(L) bits replaced by (start low bits + k) mod L. The upper bits are unchanged. For example, start 0x0D at length 8 gives 0D,0E,0F,08,09,0A,0B,0C.
- R5: With the ordering bit 1 and a fixed length L, beat k has low log2(L) bits equal to the start low bits XOR k. The upper bits are unchanged. For example, start 0x0D at length 8 gives 0D,0C,0F,0E,09,08,0B,0A.
- R6: `last_o` is 1 on the final beat of a fixed burst, and only then unless R9 applies. Once that beat is taken, `valid_o` is 0 on the next cycle.
- R7: The length code is 000 for 1 beat, 001 for 2, 010 for 4, 011 for 8 and 111 for page mode. The codes 100, 101 and 110 behave as length 1.
- R8: In page mode the column steps up by one per taken beat, modulo 2^COL_W (1023 wraps to 0), and `last_o` stays 0. The ordering bit is ignored.
- R9: While `valid_o` is 1, `term_i` high makes `last_o` 1 in the same cycle and `valid_o` 0 on the next cycle, whatever the value of `adv_i`. `col_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load a new burst |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | Ordering: 0 counts up, 1 uses XOR |
| adv_i | input | 1 | Take the current beat (ready) |
| term_i | input | 1 | Stop the running burst |
| col_o | output | COL_W | Current column |
| valid_o | output | 1 | A column is presented |
| last_o | output | 1 | Current beat is the last |

## Verification
Every registered result (`col_o`, `valid_o`) is due one clock edge after the input that causes it: a start, a taken beat or a terminate. `last_o` follows the stored beat state, and in the same cycle it also follows `term_i`. The bench sets its inputs two time units after a rising edge and checks outputs at that same point. This lets the registered values settle one edge after their cause, and lets the combinational `last_o` be read with `term_i` already applied. Stall cycles check that the column is held across an edge.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  // Length code values; anything not listed acts as a single beat.
  typedef enum logic [2:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;

  // Longest fixed burst is 8 beats.
  localparam int BEAT_W = 3;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
  parameter int COL_W = 10
) (
  input  logic [2:0]       code_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o
);
  import bcg_pkg::*;

  logic [1:0] lg;

  always_comb begin
    page_o = 1'b0;
    lg     = 2'd0;
    case (bl_code_e'(code_i))
      BL_1:    lg = 2'd0;
      BL_2:    lg = 2'd1;
      BL_4:    lg = 2'd2;
      BL_8:    lg = 2'd3;
      BL_PAGE: page_o = 1'b1;
      default: lg = 2'd0;
    endcase
  end

  // One mask bit per column bit: set inside the burst-aligned block.
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_o[i] = page_o | (i < int'(lg));
  end
endmodule

// File: rtl/bcg_next_addr.sv
module bcg_next_addr #(
  parameter int COL_W  = 10,
  parameter int BEAT_W = 3
) (
  input  logic [COL_W-1:0]  cur_i,
  input  logic [COL_W-1:0]  base_i,
  input  logic [BEAT_W-1:0] beat_nxt_i,
  input  logic [COL_W-1:0]  mask_i,
  input  logic              xor_i,
  output logic [COL_W-1:0]  nxt_o
);
  localparam int PAD_W = COL_W - BEAT_W;

  logic [COL_W-1:0] beat_ext;
  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] xor_low;

  assign beat_ext = {{PAD_W{1'b0}}, beat_nxt_i};
  assign seq_low  = (cur_i + 1'b1) & mask_i;
  assign xor_low  = (base_i ^ beat_ext) & mask_i;
  assign nxt_o    = (cur_i & ~mask_i) | (xor_i ? xor_low : seq_low);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             adv_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  import bcg_pkg::*;

  logic [COL_W-1:0]  dec_mask;
  logic              dec_page;
  logic [COL_W-1:0]  col_q, base_q, mask_q, col_nxt;
  logic [BEAT_W-1:0] beat_q, beat_nxt;
  logic              valid_q, page_q, xor_q;
  logic              end_beat;

  bcg_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i (len_code_i),
    .mask_o (dec_mask),
    .page_o (dec_page)
  );

  assign beat_nxt = beat_q + 1'b1;

  bcg_next_addr #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_nxt (
    .cur_i      (col_q),
    .base_i     (base_q),
    .beat_nxt_i (beat_nxt),
    .mask_i     (mask_q),
    .xor_i      (xor_q),
    .nxt_o      (col_nxt)
  );

  assign end_beat = !page_q && (beat_q == mask_q[BEAT_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      col_q   <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      beat_q  <= '0;
      page_q  <= 1'b0;
      xor_q   <= 1'b0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      col_q   <= start_col_i;
      base_q  <= start_col_i;
      mask_q  <= dec_mask;
      beat_q  <= '0;
      page_q  <= dec_page;
      xor_q   <= interleave_i && !dec_page;
    end else if (valid_q) begin
      if (term_i) begin
        valid_q <= 1'b0;
      end else if (adv_i) begin
        if (end_beat) begin
          valid_q <= 1'b0;
        end else begin
          col_q  <= col_nxt;
          beat_q <= beat_nxt;
        end
      end
    end
  end

  assign col_o   = col_q;
  assign valid_o = valid_q;
  assign last_o  = valid_q && (end_beat || term_i);
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_code_i,
  input logic             adv_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  a_r1_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !adv_i && !term_i && !start_i) |=> (valid_o && $stable(col_o)));

  a_r6_end_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && last_o && adv_i && !start_i) |=> !valid_o);

  a_r7_single_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (len_code_i == 3'b000 ||
                 (len_code_i[2] && len_code_i != 3'b111))) |=> last_o);

  a_r9_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && term_i && !start_i) |=> (!valid_o && $stable(col_o)));
endmodule

bind burst_col_gen bcg_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .len_code_i  (len_code_i),
  .adv_i       (adv_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic             interleave_i = 1'b0;
  logic             adv_i = 1'b0;
  logic             term_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int checks = 0;
  int errs = 0;

  always #5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .adv_i(adv_i),
    .term_i(term_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [COL_W-1:0] ecol(input logic [COL_W-1:0] sc, input int len,
                                            input bit il, input bit page, input int k);
    logic [COL_W-1:0] m;
    logic [COL_W-1:0] kk;
    kk = COL_W'(k);
    if (page) return sc + kk;
    m = COL_W'(len - 1);
    if (il) return (sc & ~m) | ((sc ^ kk) & m);
    return (sc & ~m) | ((sc + kk) & m);
  endfunction

  task automatic do_start(input logic [COL_W-1:0] sc, input logic [2:0] code, input bit il);
    start_i = 1'b1; start_col_i = sc; len_code_i = code; interleave_i = il;
    cyc();
    start_i = 1'b0; interleave_i = 1'b0;
    chk("R2 valid after start", valid_o, 1);
    chk("R2 first column", col_o, sc);
  endtask

  // Runs nb beats; a fixed burst must then end, a page burst keeps going.
  task automatic run_burst(input string tag, input logic [COL_W-1:0] sc, input logic [2:0] code,
                           input bit il, input int len, input bit page, input int nb,
                           input bit stall);
    do_start(sc, code, il);
    for (int k = 0; k < nb; k++) begin
      if (stall) begin
        adv_i = 1'b0;
        cyc();
        chk({tag, " R3 stall col"}, col_o, ecol(sc, len, il, page, k));
        chk({tag, " R3 stall valid"}, valid_o, 1);
      end
      adv_i = 1'b1;
      chk({tag, " col"}, col_o, ecol(sc, len, il, page, k));
      chk({tag, " valid"}, valid_o, 1);
      chk({tag, " R6 last"}, last_o, (!page && k == nb - 1));
      cyc();
    end
    adv_i = 1'b0;
    if (!page) begin
      chk({tag, " R6 valid drops"}, valid_o, 0);
      chk({tag, " R6 last low"}, last_o, 0);
    end
  endtask

  task automatic t_reset();
    chk("R1 valid", valid_o, 0);
    chk("R1 last", last_o, 0);
    chk("R1 col", col_o, 0);
    rst_n = 1'b1;
    cyc();
    chk("R1 idle after release", valid_o, 0);
  endtask

  task automatic t_seq_lengths();
    run_burst("R4 seq len8", 10'h00D, 3'b011, 1'b0, 8, 1'b0, 8, 1'b0);
    run_burst("R4 seq len4", 10'h12E, 3'b010, 1'b0, 4, 1'b0, 4, 1'b0);
    run_burst("R7 seq len2", 10'h3FF, 3'b001, 1'b0, 2, 1'b0, 2, 1'b0);
    run_burst("R7 len1", 10'h155, 3'b000, 1'b0, 1, 1'b0, 1, 1'b0);
  endtask

  task automatic t_interleave();
    run_burst("R5 il len8 stall", 10'h00D, 3'b011, 1'b1, 8, 1'b0, 8, 1'b1);
    run_burst("R5 il len4", 10'h2A6, 3'b010, 1'b1, 4, 1'b0, 4, 1'b0);
    run_burst("R5 il len1", 10'h0F3, 3'b000, 1'b1, 1, 1'b0, 1, 1'b0);
  endtask

  task automatic t_reserved();
    run_burst("R7 code100", 10'h047, 3'b100, 1'b0, 1, 1'b0, 1, 1'b0);
    run_burst("R7 code101", 10'h047, 3'b101, 1'b1, 1, 1'b0, 1, 1'b0);
    run_burst("R7 code110", 10'h047, 3'b110, 1'b0, 1, 1'b0, 1, 1'b0);
  endtask

  task automatic t_page_term();
    run_burst("R8 page wrap", 10'h3FD, 3'b111, 1'b1, 1024, 1'b1, 6, 1'b0);
    chk("R8 page still valid", valid_o, 1);
    chk("R8 page col after wrap", col_o, 10'h003);
    term_i = 1'b1;
    #1;
    chk("R9 last with term", last_o, 1);
    cyc();
    term_i = 1'b0;
    chk("R9 valid after term", valid_o, 0);
    chk("R9 col held", col_o, 10'h003);
  endtask

  task automatic t_fixed_term();
    do_start(10'h040, 3'b011, 1'b0);
    adv_i = 1'b1;
    cyc();
    cyc();
    chk("R4 third beat", col_o, 10'h042);
    term_i = 1'b1;
    #1;
    chk("R9 last mid burst", last_o, 1);
    cyc();
    term_i = 1'b0; adv_i = 1'b0;
    chk("R9 fixed valid drop", valid_o, 0);
    chk("R9 fixed col held", col_o, 10'h042);
  endtask

  task automatic t_restart();
    do_start(10'h020, 3'b011, 1'b0);
    adv_i = 1'b1;
    cyc();
    cyc();
    chk("R4 before restart", col_o, 10'h022);
    adv_i = 1'b0;
    run_burst("R2 restart il len4", 10'h035, 3'b010, 1'b1, 4, 1'b0, 4, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    t_reset();
    t_seq_lengths();
    t_interleave();
    t_reserved();
    t_page_term();
    t_fixed_term();
    t_restart();
    cyc();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule